// File: doc/BRIEF.md
# Serial Service Request Synchronizer and Arbiter

This block sits on the processor side of two serial ports. Each port raises a transmit and a receive buffer-transfer request, and a bank of interrupt lines comes in next to them. All of these arrive asynchronously. The block resynchronizes every line to the processor clock and records each rising edge as a pending request. When the pipeline signals an instruction boundary, it grants the highest-priority eligible request. Buffer transfers always rank above interrupts, and interrupts can be masked without losing them. An interrupt grant is followed by a one-cycle vector fetch, during which nothing else is granted.

Both ports share one compander. Each compress or expand operation occupies it for one cycle. If both ports ask in the same cycle, port 0 gets it first. A receive request on a port that has companding enabled waits for its expansion slot before it becomes pending. This means the host never sees a receive transfer whose data has not yet been expanded.

Top module: `svc_req_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `gnt`, `gnt_is_irq`, `vec_fetch` and `cmp_gnt` are all zero.
- R2: A request line that is first seen high at clock edge k becomes pending at edge k+1. With `instr_bound` high and no competing request, it is granted at edge k+2.
- R3: A grant is issued only at an edge where `instr_bound` is high. Pending requests are held for as long as it stays low.
- R4: Grant bit positions are: 0 = port 0 transmit, 1 = port 0 receive, 2 = port 1 transmit, 3 = port 1 receive, 4+i = interrupt i. When several are eligible, the lowest bit position wins. Every buffer transfer therefore ranks above every interrupt, and interrupt 0 ranks highest among the interrupts.
- R5: An interrupt whose `irq_en` bit is 0 is never granted but stays pending. It can be granted at the first boundary edge after its enable is set.
- R6: `gnt` is a one-cycle pulse with at most one bit set. `gnt_is_irq` is high exactly in the cycles where the grant bit is an interrupt.
- R7: The cycle after an interrupt grant has `vec_fetch` high and carries no grant.
- R8: A grant clears its pending request. Further rising edges from the same source while it is pending merge into one grant.
- R9: `cmp_gnt` is registered: a request seen at an edge is granted in the following cycle. Port 0 takes precedence, so port 1 is granted only in a cycle after one in which port 0 did not request.
- R10: A receive request on a port with `rx_compand` set first asks for the compander. It becomes pending at the edge that ends its compander cycle. Uncontended, it is granted 4 edges after it is first seen, and port 0 compander traffic delays it further.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| ab_req_in | input | 4 | Asynchronous buffer-transfer request lines, ordered as in R4 |
| irq_in | input | NUM_IRQ | Asynchronous interrupt request lines |
| irq_en | input | NUM_IRQ | Interrupt enables, 1 = may be granted |
| rx_compand | input | 2 | Per-port flag: received words need expansion |
| instr_bound | input | 1 | High in cycles that end at an instruction boundary |
| cmp_req | input | 2 | Per-port request for a compander cycle |
| gnt | output | 4+NUM_IRQ | One-hot grant pulse |
| gnt_is_irq | output | 1 | The current grant is an interrupt (vector fetch follows) |
| vec_fetch | output | 1 | Vector fetch cycle after an interrupt grant |
| cmp_gnt | output | 2 | Per-port compander grant |

## Verification
With `instr_bound` held high, a plain request is due three sampled cycles after the cycle in which it is driven. A request released by raising `instr_bound` or an enable is due one cycle later. An uncontended companded receive is due five cycles later, and its compander grant appears in the third cycle. The driver records each expected grant together with its due cycle number. The monitor compares at every falling edge: it pops the entry whose cycle matches and reports any grant that arrives with nothing due. Compander grants and vector-fetch cycles are checked directly at their computed cycles.

// File: rtl/svc_arb_pkg.sv
package svc_arb_pkg;
  localparam int AB_LINES = 4;  // buffer-transfer request lines (2 ports x tx/rx)
  localparam int PORTS    = 2;  // serial ports sharing the compander
endpackage

// File: rtl/svc_req_sync.sv
module svc_req_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  output logic [W-1:0] rise
);
  logic [STAGES-1:0][W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst) sreg <= '0;
    else begin
      sreg[0] <= raw;
      for (int k = 1; k < STAGES; k++) sreg[k] <= sreg[k-1];
    end
  end

  // new request: last synchronized stage has just gone high
  assign rise = sreg[STAGES-2] & ~sreg[STAGES-1];
endmodule

// File: rtl/svc_prio_pick.sv
module svc_prio_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] onehot,
  output logic         any
);
  always_comb begin
    onehot = '0;
    for (int i = 0; i < N; i++)
      if (req[i] && (onehot == '0)) onehot[i] = 1'b1;
  end
  assign any = |req;
endmodule

// File: rtl/svc_cmp_arb.sv
module svc_cmp_arb #(
  parameter int PORTS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PORTS-1:0] want,
  output logic [PORTS-1:0] gnt
);
  logic [PORTS-1:0] pick;

  always_comb begin
    pick = '0;
    for (int p = 0; p < PORTS; p++)
      if (want[p] && (pick == '0)) pick[p] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) gnt <= '0;
    else     gnt <= pick;
  end
endmodule

// File: rtl/svc_req_arbiter.sv
module svc_req_arbiter
  import svc_arb_pkg::*;
#(
  parameter int NUM_IRQ     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [AB_LINES-1:0]         ab_req_in,
  input  logic [NUM_IRQ-1:0]          irq_in,
  input  logic [NUM_IRQ-1:0]          irq_en,
  input  logic [PORTS-1:0]            rx_compand,
  input  logic                        instr_bound,
  input  logic [PORTS-1:0]            cmp_req,
  output logic [AB_LINES+NUM_IRQ-1:0] gnt,
  output logic                        gnt_is_irq,
  output logic                        vec_fetch,
  output logic [PORTS-1:0]            cmp_gnt
);
  localparam int NSRC = AB_LINES + NUM_IRQ;

  logic [NSRC-1:0]  raw_all, rise, direct_set, done_set;
  logic [NSRC-1:0]  pend_q, pend_d, eligible, cand, take;
  logic             any_elig, fire;
  logic [PORTS-1:0] wait_q, wait_set, exp_done, cmp_want;

  assign raw_all = {irq_in, ab_req_in};

  svc_req_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .raw (raw_all),
    .rise(rise)
  );

  // receive line of port p sits at bit 2p+1
  for (genvar p = 0; p < PORTS; p++) begin : g_port
    assign wait_set[p] = rise[2*p+1] & rx_compand[p];
    assign exp_done[p] = wait_q[p] & cmp_gnt[p];
    assign cmp_want[p] = cmp_req[p] | (wait_q[p] & ~cmp_gnt[p]);
  end

  always_comb begin
    direct_set = rise;
    done_set   = '0;
    for (int p = 0; p < PORTS; p++) begin
      direct_set[2*p+1] = rise[2*p+1] & ~rx_compand[p];
      done_set[2*p+1]   = exp_done[p];
    end
  end

  assign eligible = pend_q & {irq_en, {AB_LINES{1'b1}}};

  svc_prio_pick #(.N(NSRC)) i_pick (
    .req   (eligible),
    .onehot(cand),
    .any   (any_elig)
  );

  // no grant in the vector-fetch cycle following an interrupt grant
  assign fire   = instr_bound & ~gnt_is_irq & any_elig;
  assign take   = fire ? cand : '0;
  assign pend_d = (pend_q & ~take) | direct_set | done_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= '0;
      wait_q     <= '0;
      gnt        <= '0;
      gnt_is_irq <= 1'b0;
      vec_fetch  <= 1'b0;
    end else begin
      pend_q     <= pend_d;
      wait_q     <= (wait_q & ~exp_done) | wait_set;
      gnt        <= take;
      gnt_is_irq <= |take[NSRC-1:AB_LINES];
      vec_fetch  <= gnt_is_irq;
    end
  end

  svc_cmp_arb #(.PORTS(PORTS)) i_cmp (
    .clk (clk),
    .rst (rst),
    .want(cmp_want),
    .gnt (cmp_gnt)
  );
endmodule

// File: rtl/svc_req_arbiter_chk.sv
module svc_req_arbiter_chk #(
  parameter int NUM_IRQ = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_IRQ-1:0]   irq_en,
  input logic                 instr_bound,
  input logic [1:0]           cmp_req,
  input logic [4+NUM_IRQ-1:0] gnt,
  input logic                 gnt_is_irq,
  input logic                 vec_fetch,
  input logic [1:0]           cmp_gnt
);
  p_reset_r1: assert property (@(posedge clk) rst |=> (gnt == '0 && !vec_fetch && cmp_gnt == '0));
  p_bound_r3: assert property (@(posedge clk) disable iff (rst) (gnt != '0) |-> $past(instr_bound));
  p_mask_r5: assert property (@(posedge clk) disable iff (rst) (gnt[4+NUM_IRQ-1:4] & ~$past(irq_en)) == '0);
  p_onehot_r6: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt));
  p_fetch_r7: assert property (@(posedge clk) disable iff (rst) gnt_is_irq |=> (vec_fetch && gnt == '0));
  p_cmp_onehot_r9: assert property (@(posedge clk) disable iff (rst) $onehot0(cmp_gnt));
  p_cmp_prec_r9: assert property (@(posedge clk) disable iff (rst) cmp_req[0] |=> !cmp_gnt[1]);
endmodule

bind svc_req_arbiter svc_req_arbiter_chk #(.NUM_IRQ(NUM_IRQ)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .irq_en     (irq_en),
  .instr_bound(instr_bound),
  .cmp_req    (cmp_req),
  .gnt        (gnt),
  .gnt_is_irq (gnt_is_irq),
  .vec_fetch  (vec_fetch),
  .cmp_gnt    (cmp_gnt)
);

// File: tb/test_svc_req_arbiter.sv
module test_svc_req_arbiter;
  localparam int NI = 4;
  localparam int NS = 4 + NI;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0]    ab_req_in = '0;
  logic [NI-1:0] irq_in = '0;
  logic [NI-1:0] irq_en = '1;
  logic [1:0]    rx_compand = '0;
  logic          instr_bound = 1'b0;
  logic [1:0]    cmp_req = '0;
  logic [NS-1:0] gnt;
  logic          gnt_is_irq, vec_fetch;
  logic [1:0]    cmp_gnt;

  int cyc = 0, n_chk = 0, n_fail = 0;
  int    exp_cyc[$];
  int    exp_idx[$];
  string exp_req[$];

  svc_req_arbiter #(.NUM_IRQ(NI)) i_svc_req_arbiter (
    .clk(clk), .rst(rst), .ab_req_in(ab_req_in), .irq_in(irq_in), .irq_en(irq_en),
    .rx_compand(rx_compand), .instr_bound(instr_bound), .cmp_req(cmp_req),
    .gnt(gnt), .gnt_is_irq(gnt_is_irq), .vec_fetch(vec_fetch), .cmp_gnt(cmp_gnt)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  task automatic expect_gnt(int c, int idx, string req);
    exp_cyc.push_back(c); exp_idx.push_back(idx); exp_req.push_back(req);
  endtask

  task automatic wait_cyc(int c);
    while (cyc != c) @(negedge clk);
  endtask

  // monitor: pops each expected grant in its due cycle, flags any other grant
  always @(negedge clk) begin
    if (!rst) begin
      if (exp_cyc.size() > 0 && exp_cyc[0] == cyc) begin
        chk(gnt == NS'(1) << exp_idx[0], exp_req[0], int'(gnt), 1 << exp_idx[0]);
        chk(gnt_is_irq == (exp_idx[0] >= 4), "R6", int'(gnt_is_irq), int'(exp_idx[0] >= 4));
        void'(exp_cyc.pop_front()); void'(exp_idx.pop_front()); void'(exp_req.pop_front());
      end else if (gnt != '0) begin
        chk(1'b0, "R6/R8 unexpected grant", int'(gnt), 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    chk(gnt == '0 && !vec_fetch && cmp_gnt == '0, "R1", int'(gnt), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(gnt == '0 && !vec_fetch && cmp_gnt == '0 && !gnt_is_irq, "R1", int'(gnt), 0);
    instr_bound = 1'b1;

    // R2: plain request latency
    @(negedge clk); ab_req_in[2] = 1'b1; c = cyc; expect_gnt(c + 3, 2, "R2");
    @(negedge clk); ab_req_in[2] = 1'b0;
    repeat (6) @(negedge clk);

    // R3 / R4 / R7: all buffer lines plus two interrupts, held off by instr_bound
    instr_bound = 1'b0; ab_req_in = 4'hF; irq_in[1:0] = 2'b11;
    @(negedge clk); ab_req_in = '0; irq_in = '0;
    repeat (5) @(negedge clk);
    chk(gnt == '0, "R3", int'(gnt), 0);
    instr_bound = 1'b1; c = cyc;
    expect_gnt(c + 1, 0, "R4"); expect_gnt(c + 2, 1, "R4"); expect_gnt(c + 3, 2, "R4");
    expect_gnt(c + 4, 3, "R4"); expect_gnt(c + 5, 4, "R4"); expect_gnt(c + 7, 5, "R4");
    wait_cyc(c + 6); chk(vec_fetch == 1'b1, "R7", int'(vec_fetch), 1);
    wait_cyc(c + 7); chk(vec_fetch == 1'b0, "R7", int'(vec_fetch), 0);
    wait_cyc(c + 8); chk(vec_fetch == 1'b1, "R7", int'(vec_fetch), 1);
    repeat (4) @(negedge clk);

    // R5: masked interrupt stays pending
    irq_en[2] = 1'b0;
    @(negedge clk); irq_in[2] = 1'b1;
    @(negedge clk); irq_in[2] = 1'b0;
    repeat (8) @(negedge clk);
    chk(gnt == '0, "R5", int'(gnt), 0);
    irq_en[2] = 1'b1; c = cyc; expect_gnt(c + 1, 6, "R5");
    repeat (5) @(negedge clk);

    // R8: two edges while pending merge into one grant
    instr_bound = 1'b0;
    @(negedge clk); ab_req_in[0] = 1'b1;
    @(negedge clk); ab_req_in[0] = 1'b0;
    repeat (3) @(negedge clk); ab_req_in[0] = 1'b1;
    @(negedge clk); ab_req_in[0] = 1'b0;
    repeat (4) @(negedge clk);
    instr_bound = 1'b1; c = cyc; expect_gnt(c + 1, 0, "R8");
    repeat (8) @(negedge clk);
    chk(gnt == '0, "R8", int'(gnt), 0);

    // R9: compander precedence
    cmp_req = 2'b11;
    @(negedge clk); chk(cmp_gnt == 2'b01, "R9", int'(cmp_gnt), 1);
    cmp_req = 2'b10;
    @(negedge clk); chk(cmp_gnt == 2'b10, "R9", int'(cmp_gnt), 2);
    cmp_req = 2'b00;
    @(negedge clk); chk(cmp_gnt == 2'b00, "R9", int'(cmp_gnt), 0);
    repeat (3) @(negedge clk);

    // R10: companded receive on port 1, uncontended
    rx_compand = 2'b10;
    @(negedge clk); ab_req_in[3] = 1'b1; c = cyc; expect_gnt(c + 5, 3, "R10");
    @(negedge clk); ab_req_in[3] = 1'b0;
    wait_cyc(c + 3); chk(cmp_gnt == 2'b10, "R10", int'(cmp_gnt), 2);
    wait_cyc(c + 4); chk(cmp_gnt == 2'b00, "R10", int'(cmp_gnt), 0);
    repeat (5) @(negedge clk);

    // R10 with port 0 holding the compander
    @(negedge clk); ab_req_in[3] = 1'b1; cmp_req = 2'b01; c = cyc; expect_gnt(c + 8, 3, "R10");
    @(negedge clk); ab_req_in[3] = 1'b0;
    wait_cyc(c + 4); chk(cmp_gnt == 2'b01, "R9", int'(cmp_gnt), 1);
    wait_cyc(c + 5); cmp_req = 2'b00;
    wait_cyc(c + 6); chk(cmp_gnt == 2'b10, "R10", int'(cmp_gnt), 2);
    repeat (8) @(negedge clk);

    chk(exp_cyc.size() == 0, "R2 missing grants", exp_cyc.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule